// File: doc/BRIEF.md
# Snoop Admission Gate

This block sits between the external snoop request path and the cache controller inside a memory bus controller. It watches bus-grant events, each tagged with a cycle-type code, and from them tracks two kinds of blocking window: a locked read-modify-write window and a read-for-ownership window. A snoop write-back outranks every other cycle in the cache controller, so it could write a modified line back between the read and write halves of an atomic sequence. It could also return stale data while ownership of a line is moving between caches. The gate therefore holds back any snoop strobe that falls inside an open window.

A snoop that cannot go out at once is parked in a single holding register. The requester sees a stall flag while the snoop is parked, and the snoop is issued in the first cycle the obstacle clears. When relaxed mode is on, a snoop may pass through a locked window if its address lies in a different cache line from the locked address. The gate also spaces strobes apart: after a strobe, the next one waits until the cycle after the cache controller has acknowledged the snoop cycle.

Top module: `snoop_admit_gate`

## Requirements
- R1: With relaxed mode off, no strobe is issued from the cycle of a grant with kind 1 (locked first read) through the cycle of a grant with kind 2 (locked last write), both cycles included.
- R2: No strobe is issued from the cycle of a grant with kind 3 (ownership write-through) through the cycle of a grant with kind 4 (ownership allocation), both cycles included.
- R3: With relaxed mode on, a snoop inside a locked window is admitted only if its address differs from the locked address in some bit at or above bit log2(LINE_BYTES). The locked address is captured at the kind-1 grant; in the grant cycle itself, the lock_addr input is used for the comparison.
- R4: Relaxed mode has no effect on the ownership window. A snoop to a different line is still held during that window.
- R5: After a strobe, no further strobe is issued before the cycle that follows a cycle in which snp_cyc_ack is sampled high.
- R6: A request that cannot be admitted is captured with its address. snp_stall is high from the next cycle until the cycle in which the snoop issues, and the captured address is presented on snp_stb_addr. The held snoop issues in the first cycle in which no window blocks it and spacing allows.
- R7: A held snoop is not blocked by a grant that opens a new window in the same cycle. Once its blocking window has closed, it issues ahead of the new window.
- R8: A synchronous active-low reset closes both windows, drops the held request and clears the spacing wait. After reset, snp_stall is low and a request is admitted at once.
- R9: A request that meets no obstacle is strobed in the same cycle, with snp_stb_addr equal to snp_addr.
- R10: Grant kind 0 and the unused codes 5 to 7 neither open nor close any window. A grant only has an effect when grant_vld is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| relax_en | input | 1 | Relaxed mode: lets a different-line snoop pass through a locked window |
| grant_vld | input | 1 | Bus-grant pulse |
| grant_kind | input | 3 | Cycle-type code of the grant (0 other, 1 locked first read, 2 locked last write, 3 ownership write-through, 4 ownership allocation) |
| lock_addr | input | AW | Address of the locked operation, sampled with a kind-1 grant |
| snp_req | input | 1 | Snoop request pulse |
| snp_addr | input | AW | Snoop request address |
| snp_cyc_ack | input | 1 | Snoop-cycle-active acknowledgement from the cache controller |
| snp_stb | output | 1 | Snoop strobe to the cache controller |
| snp_stb_addr | output | AW | Address that goes with the strobe |
| snp_stall | output | 1 | A snoop is held; the requester must not issue another |

## Verification
The assertions assume that the requester never raises snp_req while snp_stall is high. They also assume that snp_cyc_ack arrives no earlier than the cycle after a strobe and that a single grant carries only one kind. The bench builds its stimulus from a behavioural model of the gate: it offers a request only when the model shows no held snoop, and it pulses the acknowledgement only while the model is waiting for one. The random grant kinds include the unused codes, so windows can open and close in any order.

// File: rtl/snpg_pkg.sv
// Shared definitions for the snoop admission gate.
// Assumes one grant kind per grant pulse.
package snpg_pkg;
    typedef enum logic [2:0] {
        GK_OTHER     = 3'd0,
        GK_LOCK_RD   = 3'd1,
        GK_LOCK_WR   = 3'd2,
        GK_RFO_WT    = 3'd3,
        GK_RFO_ALLOC = 3'd4
    } grant_kind_e;

    localparam int NWIN    = 2;
    localparam int WIN_LCK = 0;
    localparam int WIN_RFO = 1;
endpackage

// File: rtl/snpg_window.sv
// Tracks one blocking window between an opening and a closing grant event.
// open_q is high from the cycle after the opening grant through the closing
// grant cycle. Assumes open_ev and close_ev are never high together.
module snpg_window (
    input  logic clk,
    input  logic rst_n,
    input  logic open_ev,
    input  logic close_ev,
    output logic open_q
);
    // Window state: set on open, cleared on close, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)        open_q <= 1'b0;
        else if (open_ev)  open_q <= 1'b1;
        else if (close_ev) open_q <= 1'b0;
    end

    AST_WIN_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        close_ev |=> !open_q); // R1
    AST_WIN_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        open_ev |=> open_q); // R2
endmodule

// File: rtl/snpg_line_tag.sv
// Holds the locked address and compares a candidate snoop address with it
// at cache-line granularity. Offset bits below LINE_BYTES are ignored.
// Assumes LINE_BYTES is a power of two.
module snpg_line_tag #(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [AW-1:0] lock_addr,
    input  logic [AW-1:0] cand_addr,
    output logic [AW-1:0] lock_q,
    output logic          same_q,
    output logic          same_in
);
    localparam int OFFS = $clog2(LINE_BYTES);

    // Captures the locked address at the opening grant of a locked window.
    always_ff @(posedge clk) begin
        if (!rst_n)       lock_q <= '0;
        else if (capture) lock_q <= lock_addr;
    end

    // Line match against the stored address and against the live input.
    always_comb begin
        same_q  = ((cand_addr ^ lock_q)    >> OFFS) == '0;
        same_in = ((cand_addr ^ lock_addr) >> OFFS) == '0;
    end
endmodule

// File: rtl/snpg_space.sv
// Enforces strobe spacing: after a strobe, waits for the snoop-cycle
// acknowledgement; a new strobe may go in the cycle after the ack.
// Assumes the ack never comes in the same cycle as its strobe.
module snpg_space (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic ack,
    output logic wait_q
);
    // Wait flag: set by a strobe, cleared by the acknowledgement.
    always_ff @(posedge clk) begin
        if (!rst_n)   wait_q <= 1'b0;
        else if (stb) wait_q <= 1'b1;
        else if (ack) wait_q <= 1'b0;
    end

    AST_WAIT_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> wait_q); // R5
endmodule

// File: rtl/snoop_admit_gate.sv
// Snoop admission gate. Decides each cycle whether a snoop (held or fresh)
// may be strobed to the cache controller, given the locked and ownership
// windows, relaxed line matching and strobe spacing. A blocked snoop is
// parked in a one-entry holding register while snp_stall is high.
// Assumes the requester does not raise snp_req while snp_stall is high.
module snoop_admit_gate
    import snpg_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          relax_en,
    input  logic          grant_vld,
    input  logic [2:0]    grant_kind,
    input  logic [AW-1:0] lock_addr,
    input  logic          snp_req,
    input  logic [AW-1:0] snp_addr,
    input  logic          snp_cyc_ack,
    output logic          snp_stb,
    output logic [AW-1:0] snp_stb_addr,
    output logic          snp_stall
);
    localparam int OFFS = $clog2(LINE_BYTES);

    logic [NWIN-1:0] open_ev, close_ev, win_q;
    logic            hold_vld;
    logic [AW-1:0]   hold_addr;
    logic            cand_vld;
    logic [AW-1:0]   cand_addr;
    logic [AW-1:0]   lock_q;
    logic            same_q, same_in;
    logic            lock_hit, rfo_hit, wait_q, admit;

    // Decodes grant pulses into open and close events per window.
    always_comb begin
        open_ev[WIN_LCK]  = grant_vld && (grant_kind == GK_LOCK_RD);
        close_ev[WIN_LCK] = grant_vld && (grant_kind == GK_LOCK_WR);
        open_ev[WIN_RFO]  = grant_vld && (grant_kind == GK_RFO_WT);
        close_ev[WIN_RFO] = grant_vld && (grant_kind == GK_RFO_ALLOC);
    end

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        snpg_window u_win (
            .clk      (clk),
            .rst_n    (rst_n),
            .open_ev  (open_ev[w]),
            .close_ev (close_ev[w]),
            .open_q   (win_q[w])
        );
    end

    // Selects the candidate: a held snoop has priority over a fresh one.
    always_comb begin
        cand_vld  = hold_vld || snp_req;
        cand_addr = hold_vld ? hold_addr : snp_addr;
    end

    snpg_line_tag #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (open_ev[WIN_LCK]),
        .lock_addr (lock_addr),
        .cand_addr (cand_addr),
        .lock_q    (lock_q),
        .same_q    (same_q),
        .same_in   (same_in)
    );

    snpg_space u_space (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb    (snp_stb),
        .ack    (snp_cyc_ack),
        .wait_q (wait_q)
    );

    // Blocking terms; an opening grant does not block a snoop already held.
    always_comb begin
        lock_hit = (win_q[WIN_LCK] && (!relax_en || same_q)) ||
                   (!hold_vld && open_ev[WIN_LCK] && (!relax_en || same_in));
        rfo_hit  = win_q[WIN_RFO] || (!hold_vld && open_ev[WIN_RFO]);
        admit    = cand_vld && !lock_hit && !rfo_hit && !wait_q;
    end

    // Holding register: parks a blocked fresh request, frees on issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_vld  <= 1'b0;
            hold_addr <= '0;
        end else if (hold_vld && admit) begin
            hold_vld  <= 1'b0;
        end else if (!hold_vld && snp_req && !admit) begin
            hold_vld  <= 1'b1;
            hold_addr <= snp_addr;
        end
    end

    // Drives the strobe and stall outputs.
    always_comb begin
        snp_stb      = admit;
        snp_stb_addr = cand_addr;
        snp_stall    = hold_vld;
    end

    AST_STRICT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q[WIN_LCK] && !relax_en) |-> !snp_stb); // R1
    AST_RFO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        win_q[WIN_RFO] |-> !snp_stb); // R2
    AST_RELAX_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_stb && win_q[WIN_LCK]) |-> (((snp_stb_addr ^ lock_q) >> OFFS) != '0)); // R3
    AST_STB_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        snp_stb |=> !snp_stb); // R5
    AST_HOLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_req && !snp_stall && !snp_stb) |=> snp_stall); // R6
    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_stall && !snp_stb) |=> (snp_stall && $stable(snp_stb_addr))); // R6
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> !snp_stall); // R8
endmodule

// File: tb/snoop_admit_gate_bench.sv
`timescale 1ns/1ps
module snoop_admit_gate_bench;
    localparam int AW = 32;
    localparam int LB = 32;
    localparam int SH = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          relax_en = 1'b0;
    logic          grant_vld = 1'b0;
    logic [2:0]    grant_kind = 3'd0;
    logic [AW-1:0] lock_addr = '0;
    logic          snp_req = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic          snp_cyc_ack = 1'b0;
    logic          snp_stb;
    logic [AW-1:0] snp_stb_addr;
    logic          snp_stall;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // Behavioural model state
    bit            m_lock, m_rfo, m_wait, m_hold;
    logic [AW-1:0] m_laddr, m_haddr;

    always #4 clk = ~clk;

    snoop_admit_gate #(.AW(AW), .LINE_BYTES(LB)) u_snoop_admit_gate (
        .clk(clk), .rst_n(rst_n), .relax_en(relax_en), .grant_vld(grant_vld),
        .grant_kind(grant_kind), .lock_addr(lock_addr), .snp_req(snp_req),
        .snp_addr(snp_addr), .snp_cyc_ack(snp_cyc_ack), .snp_stb(snp_stb),
        .snp_stb_addr(snp_stb_addr), .snp_stall(snp_stall)
    );

    function automatic bit same_line(logic [AW-1:0] a, logic [AW-1:0] b);
        return (a >> SH) == (b >> SH);
    endfunction

    task automatic step(input string tag, input bit rlx, input bit gv, input int gk,
                        input logic [AW-1:0] la, input bit rq,
                        input logic [AW-1:0] sa, input bit ak);
        bit cvld, lb, rb, e_stb, ol, cl, orf, crf;
        logic [AW-1:0] caddr;
        @(negedge clk);
        relax_en = rlx; grant_vld = gv; grant_kind = 3'(gk); lock_addr = la;
        snp_req = rq; snp_addr = sa; snp_cyc_ack = ak;
        #1;
        ol  = gv && gk == 1; cl  = gv && gk == 2;
        orf = gv && gk == 3; crf = gv && gk == 4;
        cvld  = m_hold || rq;
        caddr = m_hold ? m_haddr : sa;
        lb = 0;
        if (m_lock && (!rlx || same_line(caddr, m_laddr))) lb = 1;
        if (!m_hold && ol && (!rlx || same_line(caddr, la))) lb = 1;
        rb = m_rfo || (!m_hold && orf);
        e_stb = cvld && !lb && !rb && !m_wait;
        vectors++;
        if (snp_stb !== e_stb || snp_stall !== m_hold ||
            (e_stb && snp_stb_addr !== caddr)) begin
            errors++;
            $display("FAIL %s: stb=%b stall=%b addr=%h expected stb=%b stall=%b addr=%h",
                     tag, snp_stb, snp_stall, snp_stb_addr, e_stb, m_hold, caddr);
        end
        if (ol) begin m_lock = 1; m_laddr = la; end
        else if (cl) m_lock = 0;
        if (orf) m_rfo = 1; else if (crf) m_rfo = 0;
        if (e_stb) m_wait = 1; else if (ak) m_wait = 0;
        if (m_hold && e_stb) m_hold = 0;
        else if (!m_hold && rq && !e_stb) begin m_hold = 1; m_haddr = sa; end
    endtask

    task automatic idle(input string tag, input bit rlx);
        step(tag, rlx, 0, 0, '0, 0, '0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; grant_vld = 0; snp_req = 0; snp_cyc_ack = 0;
        repeat (2) @(posedge clk);
        m_lock = 0; m_rfo = 0; m_wait = 0; m_hold = 0; m_laddr = '0; m_haddr = '0;
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        idle("R8 reset state", 0);
        // R9 and R5: free admission, then spacing holds a second request
        step("R9 free strobe", 0, 0, 0, '0, 1, 32'h0000_1000, 0);
        step("R5 req before ack", 0, 0, 0, '0, 1, 32'h0000_2000, 0);
        step("R5 ack cycle", 0, 0, 0, '0, 0, '0, 1);
        idle("R5 issue after ack", 0);
        step("R5 ack", 0, 0, 0, '0, 0, '0, 1);
        // R1: strict locked window
        step("R1 lock open with req", 0, 1, 1, 32'h0000_4000, 1, 32'h0000_9000, 0);
        idle("R1 inside", 0);
        step("R10 kind 0 no effect", 0, 1, 0, '0, 0, '0, 0);
        step("R10 kind 6 no effect", 0, 1, 6, '0, 0, '0, 0);
        step("R10 kind 2 without vld", 0, 0, 2, '0, 0, '0, 0);
        step("R1 lock close", 0, 1, 2, '0, 0, '0, 0);
        idle("R6 issue after close", 0);
        step("R6 ack", 0, 0, 0, '0, 0, '0, 1);
        // R2: ownership window
        step("R2 rfo open", 0, 1, 3, '0, 0, '0, 0);
        step("R2 req held", 0, 0, 0, '0, 1, 32'h0000_a000, 0);
        step("R10 kind 5", 0, 1, 5, '0, 0, '0, 0);
        step("R2 rfo close", 0, 1, 4, '0, 0, '0, 0);
        idle("R6 issue after rfo", 0);
        step("R6 ack", 0, 0, 0, '0, 0, '0, 1);
        // R3: relaxed locked window
        step("R3 open, other line", 1, 1, 1, 32'h0000_4010, 1, 32'h0000_4020, 0);
        step("R3 ack", 1, 0, 0, '0, 0, '0, 1);
        step("R3 same line held", 1, 0, 0, '0, 1, 32'h0000_401c, 0);
        step("R3 close", 1, 1, 2, '0, 0, '0, 0);
        idle("R3 issue", 1);
        step("R3 ack", 1, 0, 0, '0, 0, '0, 1);
        step("R3 open same line same cycle", 1, 1, 1, 32'h0000_8000, 1, 32'h0000_8004, 0);
        step("R3 close", 1, 1, 2, '0, 0, '0, 0);
        idle("R3 issue", 1);
        step("R3 ack", 1, 0, 0, '0, 0, '0, 1);
        // R4: relax does not open the ownership window
        step("R4 rfo open", 1, 1, 3, '0, 0, '0, 0);
        step("R4 other line held", 1, 0, 0, '0, 1, 32'h0001_0000, 0);
        step("R4 close", 1, 1, 4, '0, 0, '0, 0);
        idle("R4 issue", 1);
        step("R4 ack", 1, 0, 0, '0, 0, '0, 1);
        // R7: held snoop beats a window opening right after close
        step("R7 lock open", 0, 1, 1, 32'h0000_c000, 0, '0, 0);
        step("R7 req held", 0, 0, 0, '0, 1, 32'h0000_d000, 0);
        step("R7 lock close", 0, 1, 2, '0, 0, '0, 0);
        step("R7 reopen with held", 0, 1, 1, 32'h0000_c000, 0, '0, 0);
        step("R7 ack", 0, 0, 0, '0, 0, '0, 1);
        step("R7 new req blocked", 0, 0, 0, '0, 1, 32'h0000_e000, 0);
        // R8: reset with window open and snoop held
        step("R8 rfo open", 0, 1, 3, '0, 0, '0, 0);
        do_reset();
        idle("R8 stall cleared", 0);
        step("R8 admitted after reset", 0, 0, 0, '0, 1, 32'h0000_f000, 0);
        step("R8 ack", 0, 0, 0, '0, 0, '0, 1);
        // Random traffic within the input assumptions
        for (int i = 0; i < 4000; i++) begin
            bit rlx, gv, rq, ak;
            int gk;
            logic [AW-1:0] sa, la;
            rlx = (i / 500) % 2;
            gv  = ($urandom % 4) == 0;
            gk  = $urandom % 8;
            la  = {20'h0, 12'($urandom)} & 32'h0000_03ff;
            sa  = {20'h0, 12'($urandom)} & 32'h0000_03ff;
            rq  = !m_hold && (($urandom % 3) == 0);
            ak  = m_wait && (($urandom % 3) == 0);
            step("R9 random", rlx, gv, gk, la, rq, sa, ak);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule